// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codec for an 8-bit Memory Word

This block protects an 8-bit memory word with four Hamming check bits and one extra overall parity bit. It has two independent sides. The write side takes a data byte and returns the check bits and the parity bit that are to be stored beside it. The read side takes a stored byte, its check bits and its parity bit, and recomputes the check bits. The XOR of the stored and recomputed check bits forms a syndrome. It then corrects any single flipped bit in the 12-bit field that holds the data and the check bits. A double flip is detected and flagged but left uncorrected.

The check bits and the data bits share one numbering of codeword positions, so the syndrome value is itself the number of the failing position. The overall parity bit tells a single error apart from a double error. Each side has one register stage. A result appears in the cycle after its valid input and stays in place until the next valid input arrives.

The read side sorts every word into one of three classes. A clean word has a zero syndrome and even overall parity. A single-error word has odd overall parity and gets a correction. A double-error word has a nonzero syndrome and even overall parity, and its data is passed through untouched.

Top module: `secded_codec`

## Requirements
- R1: Codeword positions 1, 2, 4 and 8 hold the check bits, and data bits 0 to 7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Check bit k, with `wr_chk[k]` holding the position-2^k bit, is the XOR of the data bits whose position number has bit k set. For example, data 8'b00111001 gives `wr_chk` = 4'b0111.
- R2: `wr_par` is chosen so that the 8 data bits, the 4 check bits and the parity bit together hold an even number of ones.
- R3: `wr_out_valid`, `wr_chk` and `wr_par` update in the cycle after `wr_valid` is high. `wr_out_valid` is low in the cycle after `wr_valid` is low.
- R4: An unaltered codeword reads back with the same data, syndrome 0, and `rd_single` and `rd_double` both low.
- R5: When exactly one data bit is flipped, `rd_out_syn` equals that bit's codeword position, `rd_single` is high, and `rd_out_data` is the original data. For example, data 8'b00111101 read with the check bits of 8'b00111001 gives syndrome 4'b0110.
- R6: When exactly one check bit is flipped, `rd_out_syn` is that bit's position (1, 2, 4 or 8). When only the parity bit is flipped, `rd_out_syn` is 0. In both cases `rd_single` is high and the data passes through unchanged.
- R7: When two bits of the 13 are flipped, `rd_double` is high, `rd_single` is low, `rd_out_syn` is the XOR of the two positions (the parity bit counts as 0), and `rd_out_data` equals the received data.
- R8: A nonzero syndrome above 12 together with odd overall parity raises `rd_single` and leaves the received data unchanged.
- R9: `rd_out_valid` and the read results update in the cycle after `rd_valid` is high. `rd_out_valid` is low in the cycle after `rd_valid` is low.
- R10: While `rst_n` is low, every output is 0.
- R11: `rd_single` and `rd_double` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write-side data is present |
| wr_data | input | 8 | Data byte to encode |
| wr_out_valid | output | 1 | Write-side result is present |
| wr_chk | output | 4 | Check bits; bit k covers positions with bit k set |
| wr_par | output | 1 | Overall parity bit (even over 13 bits) |
| rd_valid | input | 1 | Read-side word is present |
| rd_data | input | 8 | Stored data byte |
| rd_chk | input | 4 | Stored check bits |
| rd_par | input | 1 | Stored overall parity bit |
| rd_out_valid | output | 1 | Read-side result is present |
| rd_out_data | output | 8 | Corrected or passed-through data |
| rd_out_syn | output | 4 | Syndrome, the number of the failing position |
| rd_single | output | 1 | A single error was seen (and corrected if it hit data) |
| rd_double | output | 1 | A double error was seen, data left uncorrected |

## Verification
The hardest situation to reach from the ports is a syndrome above 12 that arrives with odd overall parity. No single or double flip can produce it, so the stimulus builds it on purpose from three flips at positions 1, 2 and 12, which give syndrome 15. Beyond that, the bench encodes every one of the 256 data bytes with its own arithmetic model. Each byte is read back clean, with each of the 13 single flips and with each of the 78 pairs of flips. This covers every class and every syndrome value that one or two flips can produce.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int CW_W   = DATA_W + CHK_W;

    typedef enum logic [1:0] {
        EC_CLEAN  = 2'd0,
        EC_SINGLE = 2'd1,
        EC_DOUBLE = 2'd2
    } ecc_class_e;

    // Codeword position (1-based) of data bit idx: the idx-th position
    // that is not a power of two.
    function automatic int dpos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Positions covered by check bit k: those whose number has bit k set.
    function automatic logic [CW_W:1] cover_mask(input int k);
        logic [CW_W:1] m;
        m = '0;
        for (int p = 1; p <= CW_W; p++) begin
            m[p] = ((p >> k) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o,
    output logic              par_o
);

    logic [CW_W:1] pos_vec;

    // Scatter data bits into their codeword positions; check slots stay 0.
    always_comb begin
        pos_vec = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos_vec[dpos(i)] = data_i[i];
        end
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        assign chk_o[k] = ^(pos_vec & cover_mask(k));
    end

    assign par_o = ^{data_i, chk_o};

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    input  logic              par_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  syn_o,
    output ecc_class_e        cls_o
);

    logic [CHK_W-1:0] re_chk;
    logic             re_par;
    logic             par_odd;
    logic             syn_nz;
    logic             fix_en;

    secded_enc u_reenc (
        .data_i (data_i),
        .chk_o  (re_chk),
        .par_o  (re_par)
    );

    assign syn_o   = re_chk ^ chk_i;
    assign syn_nz  = |syn_o;
    // Total parity of the received 13 bits, folded through the recomputed word.
    assign par_odd = re_par ^ par_i ^ (^syn_o);

    always_comb begin
        unique case ({syn_nz, par_odd})
            2'b00:   cls_o = EC_CLEAN;
            2'b01:   cls_o = EC_SINGLE;
            2'b11:   cls_o = EC_SINGLE;
            default: cls_o = EC_DOUBLE;
        endcase
    end

    assign fix_en = (cls_o == EC_SINGLE) && syn_nz;

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        assign data_o[i] = data_i[i] ^ (fix_en && (syn_o == CHK_W'(dpos(i))));
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_out_valid,
    output logic [CHK_W-1:0]  wr_chk,
    output logic              wr_par,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    input  logic              rd_par,
    output logic              rd_out_valid,
    output logic [DATA_W-1:0] rd_out_data,
    output logic [CHK_W-1:0]  rd_out_syn,
    output logic              rd_single,
    output logic              rd_double
);

    logic [CHK_W-1:0]  enc_chk;
    logic              enc_par;
    logic [DATA_W-1:0] dec_data;
    logic [CHK_W-1:0]  dec_syn;
    ecc_class_e        dec_cls;
    logic              nxt_single;
    logic              nxt_double;

    secded_enc u_wr_enc (
        .data_i (wr_data),
        .chk_o  (enc_chk),
        .par_o  (enc_par)
    );

    secded_dec u_rd_dec (
        .data_i (rd_data),
        .chk_i  (rd_chk),
        .par_i  (rd_par),
        .data_o (dec_data),
        .syn_o  (dec_syn),
        .cls_o  (dec_cls)
    );

    always_comb begin
        unique case (dec_cls)
            EC_SINGLE: begin nxt_single = 1'b1; nxt_double = 1'b0; end
            EC_DOUBLE: begin nxt_single = 1'b0; nxt_double = 1'b1; end
            default:   begin nxt_single = 1'b0; nxt_double = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_out_valid <= 1'b0;
            wr_chk       <= '0;
            wr_par       <= 1'b0;
        end else begin
            wr_out_valid <= wr_valid;
            if (wr_valid) begin
                wr_chk <= enc_chk;
                wr_par <= enc_par;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_out_valid <= 1'b0;
            rd_out_data  <= '0;
            rd_out_syn   <= '0;
            rd_single    <= 1'b0;
            rd_double    <= 1'b0;
        end else begin
            rd_out_valid <= rd_valid;
            if (rd_valid) begin
                rd_out_data <= dec_data;
                rd_out_syn  <= dec_syn;
                rd_single   <= nxt_single;
                rd_double   <= nxt_double;
            end
        end
    end

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
    import secded_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_out_valid,
    input logic [CHK_W-1:0]  wr_chk,
    input logic              wr_par,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [CHK_W-1:0]  rd_chk,
    input logic              rd_par,
    input logic              rd_out_valid,
    input logic [DATA_W-1:0] rd_out_data,
    input logic [CHK_W-1:0]  rd_out_syn,
    input logic              rd_single,
    input logic              rd_double
);

    a_r2_even_total: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out_valid |-> (^{$past(wr_data), wr_chk, wr_par}) == 1'b0);

    a_r3_wr_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> wr_out_valid);

    a_r3_wr_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !wr_out_valid);

    a_r4_clean_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && rd_out_syn == '0 && !rd_single)
            |-> (!rd_double && rd_out_data == $past(rd_data)));

    a_r5_one_bit_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && rd_single && !$onehot0(rd_out_syn) && rd_out_syn <= CHK_W'(CW_W))
            |-> $countones(rd_out_data ^ $past(rd_data)) == 1);

    a_r6_check_slot_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && rd_single && $onehot0(rd_out_syn))
            |-> rd_out_data == $past(rd_data));

    a_r7_double_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && rd_double) |-> (rd_out_data == $past(rd_data) && rd_out_syn != '0));

    a_r8_high_syn_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && rd_single && rd_out_syn > CHK_W'(CW_W))
            |-> rd_out_data == $past(rd_data));

    a_r9_rd_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_out_valid);

    a_r9_rd_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rd_out_valid);

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_single && rd_double));

endmodule

bind secded_codec secded_codec_chk u_chk (.*);

// File: tb/secded_codec_tb.sv
module secded_codec_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_out_valid;
    logic [3:0] wr_chk;
    logic       wr_par;
    logic       rd_valid = 1'b0;
    logic [7:0] rd_data = '0;
    logic [3:0] rd_chk = '0;
    logic       rd_par = 1'b0;
    logic       rd_out_valid;
    logic [7:0] rd_out_data;
    logic [3:0] rd_out_syn;
    logic       rd_single;
    logic       rd_double;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    secded_codec u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_out_valid(wr_out_valid), .wr_chk(wr_chk), .wr_par(wr_par),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk), .rd_par(rd_par),
        .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data),
        .rd_out_syn(rd_out_syn), .rd_single(rd_single), .rd_double(rd_double)
    );

    // Bench codeword: index 0 = overall parity, 1..12 = positions.
    function automatic logic [12:0] b_enc(input logic [7:0] d);
        logic [12:0] cw;
        int m;
        cw = '0;
        m = 0;
        for (int p = 1; p <= 12; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[m];
                m++;
            end
        end
        for (int k = 0; k < 4; k++) begin
            logic c;
            c = 1'b0;
            for (int p = 1; p <= 12; p++) begin
                if (((p & (p - 1)) != 0) && (((p >> k) & 1) == 1)) c = c ^ cw[p];
            end
            cw[1 << k] = c;
        end
        cw[0] = ^cw[12:1];
        return cw;
    endfunction

    function automatic logic [7:0] b_data(input logic [12:0] cw);
        logic [7:0] d;
        int m;
        d = '0;
        m = 0;
        for (int p = 1; p <= 12; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[m] = cw[p];
                m++;
            end
        end
        return d;
    endfunction

    function automatic logic [3:0] b_chk(input logic [12:0] cw);
        return {cw[8], cw[4], cw[2], cw[1]};
    endfunction

    task automatic tally(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        logic [12:0] cw;
        cw = b_enc(d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        tally(wr_out_valid == 1'b1, "R3", "write valid", 32'(wr_out_valid), 32'd1);
        tally(wr_chk == b_chk(cw), "R1", "check bits", 32'(wr_chk), 32'(b_chk(cw)));
        tally(wr_par == cw[0], "R2", "parity bit", 32'(wr_par), 32'(cw[0]));
        @(negedge clk);
        tally(wr_out_valid == 1'b0, "R3", "write idle", 32'(wr_out_valid), 32'd0);
    endtask

    task automatic do_read(input logic [12:0] cw, input logic [7:0] exp_d,
                           input logic [3:0] exp_s, input bit exp_one,
                           input bit exp_two, input string req);
        @(negedge clk);
        tally(rd_out_valid == 1'b0, "R9", "read idle", 32'(rd_out_valid), 32'd0);
        rd_valid = 1'b1;
        rd_data  = b_data(cw);
        rd_chk   = b_chk(cw);
        rd_par   = cw[0];
        @(negedge clk);
        rd_valid = 1'b0;
        tally(rd_out_valid == 1'b1, "R9", "read valid", 32'(rd_out_valid), 32'd1);
        tally(rd_out_data == exp_d && rd_out_syn == exp_s &&
              rd_single == exp_one && rd_double == exp_two, req, "read result",
              {16'd0, rd_out_data, rd_out_syn, 2'b00, rd_single, rd_double},
              {16'd0, exp_d, exp_s, 2'b00, exp_one, exp_two});
        tally(!(rd_single && rd_double), "R11", "flags exclusive",
              {30'd0, rd_single, rd_double}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tally(wr_out_valid == 0 && wr_chk == 0 && wr_par == 0 && rd_out_valid == 0 &&
              rd_out_data == 0 && rd_out_syn == 0 && rd_single == 0 && rd_double == 0,
              "R10", "reset outputs",
              {17'd0, wr_out_valid, wr_chk, wr_par, rd_out_valid, rd_out_data},
              32'd0);
        rst_n = 1'b1;

        // Stated example and the M3 flip example.
        do_write(8'b0011_1001);
        tally(wr_chk == 4'b0111, "R1", "example check bits", 32'(wr_chk), 32'h7);
        begin
            logic [12:0] cw;
            cw = b_enc(8'b0011_1001);
            cw[6] = ~cw[6];
            do_read(cw, 8'b0011_1001, 4'b0110, 1'b1, 1'b0, "R5");
        end

        // Three flips giving syndrome 15 with odd parity.
        begin
            logic [12:0] cw;
            cw = b_enc(8'h5A);
            cw[1]  = ~cw[1];
            cw[2]  = ~cw[2];
            cw[12] = ~cw[12];
            do_read(cw, b_data(cw), 4'd15, 1'b1, 1'b0, "R8");
        end

        for (int d = 0; d < 256; d++) begin
            logic [12:0] good;
            good = b_enc(8'(d));
            do_write(8'(d));
            do_read(good, 8'(d), 4'd0, 1'b0, 1'b0, "R4");
            for (int i = 0; i < 13; i++) begin
                logic [12:0] bad;
                bit is_data;
                bad = good;
                bad[i] = ~bad[i];
                is_data = (i != 0) && ((i & (i - 1)) != 0);
                do_read(bad, 8'(d), 4'(i), 1'b1, 1'b0, is_data ? "R5" : "R6");
            end
            for (int i = 0; i < 13; i++) begin
                for (int j = i + 1; j < 13; j++) begin
                    logic [12:0] bad;
                    bad = good;
                    bad[i] = ~bad[i];
                    bad[j] = ~bad[j];
                    do_read(bad, b_data(bad), 4'(i ^ j), 1'b0, 1'b1, "R7");
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule